// File: doc/BRIEF.md
# Double-Buffered Output Colour Matrix

This block converts each pixel of a stream with a 3x4 colour matrix. Every output channel is the sum of three products, one per input channel, plus a signed offset. The sum is then rounded and clamped to the unsigned pixel range. Two complete coefficient banks, A and B, are held side by side. Software reads the status to learn which bank is live, writes the idle bank, and then requests that bank through the mode register.

A mode request never lands mid-frame. It waits in a pending register until a frame-start pulse. At that pulse the pending mode becomes the active mode, and the chosen bank is copied into a working coefficient set that the datapath uses. The disabled mode passes pixels through unchanged and needs no coefficients. The pixel interface is a valid/ready stream with a single registered output stage.

Top module: `ocm_matrix`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, act_mode reads 0 (disabled), and all coefficients are zero.
- R2: A write to address 15 sets the pending mode from wr_data[1:0]. The encodings are 0 = disabled, 1 = bank A and 2 = bank B. The value 3 is stored as disabled. act_mode reports the active mode with the same encoding.
- R3: A pending mode becomes active only at a clock edge where frame_start is 1, and act_mode shows it from that edge on. Until then, pixels are processed in the previous mode.
- R4: Coefficient writes use address bit 3 to pick the bank (0 = A, 1 = B) and bits 2:0 to pick a pair index p from 0 to 5. wr_data[15:0] goes to coefficient 2p and wr_data[31:16] to coefficient 2p+1. Coefficient index 4r+c is row r, column c. Pair indices 6 and 7 are ignored.
- R5: In disabled mode each accepted pixel appears unchanged at out_pix one cycle later, with no coefficient programming needed.
- R6: In bank mode, output channel r is computed as follows. Take the sum over c = 0..2 of C[r][c]·x[c], add C[r][3]·2^13, and add 2^12. Shift the result arithmetically right by 13. Coefficients are signed 16-bit values with 13 fraction bits, and the offset is in pixel LSBs. Channel c occupies in_pix bits [16c+15:16c].
- R7: A channel result below 0 is output as 0, and one above 65535 is output as 65535.
- R8: Coefficient writes have no effect on the output until a later frame_start selects their bank. This holds even for writes to the bank that is currently active.
- R9: in_ready equals !out_valid || out_ready. While out_valid is 1 and out_ready is 0, out_pix and out_valid hold.
- R10: With out_ready held at 1, one pixel is accepted per cycle, and results leave in order with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| frame_start | input | 1 | Frame boundary pulse |
| act_mode | output | 2 | Active mode status |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when valid |
| in_pix | input | 48 | Input pixel, three 16-bit channels |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream ready |
| out_pix | output | 48 | Output pixel, three 16-bit channels |

## Verification
A corrupt working coefficient copy shows up in the first pixel accepted after the frame boundary that loaded it, as a wrong channel value one cycle later. A wrong pending or active mode shows up in one of two ways. It either changes act_mode at an edge with no frame_start, or it makes a pixel bypass when it should be converted (or the reverse) in the cycle after acceptance. Address decode faults put a coefficient in the wrong row or column, and this is exposed by matrices whose entries all differ.

// File: rtl/ocm_matrix.sv
module ocm_matrix #(
  parameter int PIX_W  = 16,
  parameter int COEF_W = 16,
  parameter int FRAC   = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [3:0]           wr_addr,
  input  logic [31:0]          wr_data,
  input  logic                 frame_start,
  output logic [1:0]           act_mode,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [3*PIX_W-1:0]   in_pix,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [3*PIX_W-1:0]   out_pix
);
  localparam int NCOEF = 12;
  localparam int ACC_W = PIX_W + COEF_W + FRAC;
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC - 1);
  localparam logic signed [ACC_W-1:0] MAXV = (ACC_W'(1) <<< PIX_W) - 1;

  logic signed [COEF_W-1:0] bank_a [NCOEF];
  logic signed [COEF_W-1:0] bank_b [NCOEF];
  logic signed [COEF_W-1:0] live   [NCOEF];
  logic [1:0]               pend_mode;
  logic [3*PIX_W-1:0]       mat_pix;

  wire [2:0] pair     = wr_addr[2:0];
  wire       coef_wr  = wr_en && (pair < 3'd6);
  wire       mode_wr  = wr_en && (wr_addr == 4'hF);
  wire       use_mat  = (act_mode == 2'd1) || (act_mode == 2'd2);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCOEF; i++) begin
        bank_a[i] <= '0;
        bank_b[i] <= '0;
      end
    end else if (coef_wr) begin
      if (!wr_addr[3]) begin
        bank_a[2*pair]   <= wr_data[COEF_W-1:0];
        bank_a[2*pair+1] <= wr_data[16 +: COEF_W];
      end else begin
        bank_b[2*pair]   <= wr_data[COEF_W-1:0];
        bank_b[2*pair+1] <= wr_data[16 +: COEF_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_mode <= 2'd0;
      act_mode  <= 2'd0;
      for (int i = 0; i < NCOEF; i++) live[i] <= '0;
    end else begin
      if (mode_wr) pend_mode <= (wr_data[1:0] == 2'd3) ? 2'd0 : wr_data[1:0];
      if (frame_start) begin
        act_mode <= pend_mode;
        if (pend_mode == 2'd1) live <= bank_a;
        else if (pend_mode == 2'd2) live <= bank_b;
      end
    end
  end

  for (genvar g = 0; g < 3; g++) begin : g_row
    logic signed [ACC_W-1:0] acc, shr;
    wire signed [PIX_W:0] x0 = {1'b0, in_pix[0*PIX_W +: PIX_W]};
    wire signed [PIX_W:0] x1 = {1'b0, in_pix[1*PIX_W +: PIX_W]};
    wire signed [PIX_W:0] x2 = {1'b0, in_pix[2*PIX_W +: PIX_W]};
    always_comb begin
      acc = ACC_W'(live[4*g] * x0) + ACC_W'(live[4*g+1] * x1)
          + ACC_W'(live[4*g+2] * x2) + (ACC_W'(live[4*g+3]) <<< FRAC) + HALF;
      shr = acc >>> FRAC;
      if (shr < 0)         mat_pix[g*PIX_W +: PIX_W] = '0;
      else if (shr > MAXV) mat_pix[g*PIX_W +: PIX_W] = '1;
      else                 mat_pix[g*PIX_W +: PIX_W] = shr[PIX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_pix <= use_mat ? mat_pix : in_pix;
    end
  end
endmodule

module ocm_matrix_chk #(
  parameter int PIX_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_start,
  input logic [1:0]         act_mode,
  input logic               in_valid,
  input logic               in_ready,
  input logic [3*PIX_W-1:0] in_pix,
  input logic               out_valid,
  input logic               out_ready,
  input logic [3*PIX_W-1:0] out_pix
);
  AST_MODE_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(act_mode)); // R3
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    act_mode != 2'd3); // R2
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && act_mode != 2'd1 && act_mode != 2'd2) |=> out_pix == $past(in_pix)); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_pix)); // R9
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R9
endmodule

bind ocm_matrix ocm_matrix_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .act_mode(act_mode),
  .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
  .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
);

// File: tb/ocm_matrix_tb.sv
`timescale 1ns/100ps
module ocm_matrix_tb;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, frame_start = 0, in_valid = 0, out_ready = 1;
  logic [3:0]  wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic [47:0] in_pix = 0;
  logic [1:0]  act_mode;
  logic        in_ready, out_valid;
  logic [47:0] out_pix;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  ocm_matrix u_dut (.*);

  localparam logic [47:0] VEC [8] = '{
    48'h0000_0000_0000, 48'hFFFF_FFFF_FFFF, 48'h8000_4000_2000, 48'h0001_0002_0003,
    48'h1234_5678_9ABC, 48'hFFFF_0000_7FFF, 48'h0100_0200_0300, 48'h3C00_C000_0FF0 };

  int m1 [12] = '{8192, 0, 0, 100,   1000, 6000, 1192, -50,   0, 0, 4096, 0};
  int m2 [12] = '{32767, 32767, 0, 0, -16384, 0, 0, -20,   4096, 4096, 0, 5};
  int m3 [12] = '{32767, 32767, 0, 0, -16384, 0, 0, -20,   4096, 4096, 0, 1000};

  function automatic logic [47:0] model(int c[12], logic [47:0] p);
    logic [47:0] r;
    for (int k = 0; k < 3; k++) begin
      longint acc = longint'(c[4*k]) * p[15:0] + longint'(c[4*k+1]) * p[31:16]
                  + longint'(c[4*k+2]) * p[47:32] + longint'(c[4*k+3]) * 8192 + 4096;
      acc = acc >>> 13;
      if (acc < 0) acc = 0;
      if (acc > 65535) acc = 65535;
      r[16*k +: 16] = acc[15:0];
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic prog(bit bank, int c[12]);
    for (int p = 0; p < 6; p++) wr({bank, 3'(p)}, {c[2*p+1][15:0], c[2*p][15:0]});
  endtask

  task automatic frame();
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
  endtask

  task automatic xfer(logic [47:0] p, output logic [47:0] r);
    @(negedge clk); in_valid = 1; in_pix = p;
    @(negedge clk); in_valid = 0; r = out_pix;
    chk("R10 out_valid", {47'd0, out_valid}, 48'd1);
  endtask

  initial begin
    logic [47:0] r;
    repeat (3) @(negedge clk);
    chk("R1 out_valid", {47'd0, out_valid}, 48'd0);
    chk("R1 in_ready", {47'd0, in_ready}, 48'd1);
    chk("R1 act_mode", {46'd0, act_mode}, 48'd0);
    rst_n = 1;

    foreach (VEC[i]) begin
      xfer(VEC[i], r);
      chk("R5 bypass", r, VEC[i]);
    end

    prog(1'b0, m1);
    wr(4'hF, 32'd1);
    chk("R3 no change before frame", {46'd0, act_mode}, 48'd0);
    xfer(VEC[2], r);
    chk("R3 still bypass", r, VEC[2]);
    frame();
    chk("R2 R3 act_mode A", {46'd0, act_mode}, 48'd1);
    foreach (VEC[i]) begin
      xfer(VEC[i], r);
      chk("R6 R4 bank A", r, model(m1, VEC[i]));
    end

    prog(1'b1, m2);
    wr(4'h6, 32'hFFFF_FFFF);
    xfer(VEC[4], r);
    chk("R8 idle bank write", r, model(m1, VEC[4]));
    wr(4'hF, 32'd2);
    frame();
    chk("R2 act_mode B", {46'd0, act_mode}, 48'd2);
    foreach (VEC[i]) begin
      xfer(VEC[i], r);
      chk("R7 R6 bank B", r, model(m2, VEC[i]));
    end

    prog(1'b1, m3);
    xfer(VEC[6], r);
    chk("R8 active bank write ignored", r, model(m2, VEC[6]));
    frame();
    xfer(VEC[6], r);
    chk("R8 reloaded at frame", r, model(m3, VEC[6]));

    @(negedge clk); out_ready = 0; in_valid = 1; in_pix = VEC[4];
    @(negedge clk); in_pix = VEC[5];
    chk("R9 in_ready low", {47'd0, in_ready}, 48'd0);
    @(negedge clk);
    chk("R9 hold", out_pix, model(m3, VEC[4]));
    chk("R9 hold valid", {47'd0, out_valid}, 48'd1);
    out_ready = 1;
    @(negedge clk); in_valid = 0;
    chk("R9 second after release", out_pix, model(m3, VEC[5]));

    @(negedge clk); in_valid = 1; in_pix = VEC[1];
    @(negedge clk); in_pix = VEC[2];
    chk("R10 first", out_pix, model(m3, VEC[1]));
    @(negedge clk); in_valid = 0;
    chk("R10 second", out_pix, model(m3, VEC[2]));

    wr(4'hF, 32'd3);
    frame();
    chk("R2 code 3 is disabled", {46'd0, act_mode}, 48'd0);
    xfer(VEC[4], r);
    chk("R5 bypass again", r, VEC[4]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule